// File: doc/BRIEF.md
# Request Latency Phase Profiler

This block gathers latency statistics for memory requests that have finished. Each cycle it can accept one completion record. A record carries five timestamps: issue, initial request, forward, first response and completion. It also carries a hit/miss flag, a request-type code and a responder code. The block turns the record into bin increments across a set of saturating histogram counters.

The total latency is the completion time minus the issue time. It is always binned into an overall histogram and into a histogram for the record's type. It is also binned into either the hit histogram or the miss histogram. For a miss that names a valid responder, the block checks whether the five timestamps are in non-decreasing order. If they are, the four phase gaps go into that responder's four phase histograms. If they are not, the responder's incomplete counter is bumped instead. A combinational read port selects any counter by histogram index and bin, and a synchronous clear zeroes every counter.

The pipeline has two stages. The first stage registers the ordering test and all bin indices. The second stage updates the counters. Bins are 2^BIN_SHIFT cycles wide, and the last bin collects every larger value.

Top module: `lat_phase_prof`

## Requirements
- R1: A record is accepted when `cmp_valid` is high and `t_done >= t_issue`. Its latency `t_done - t_issue` falls into bin `min(lat >> BIN_SHIFT, NBIN-1)`. That bin is incremented in histogram 0 (overall) and in histogram `3 + cmp_type` (per type, type codes 0 to 2^TYPE_W-1).
- R2: An accepted record with `cmp_hit`=1 increments the same bin in histogram 1 (hit). One with `cmp_hit`=0 increments it in histogram 2 (miss).
- R3: An accepted miss whose responder code `r` is below NRESP, and whose timestamps satisfy issue <= init <= fwd <= first <= done (equality allowed), increments four histograms. Histogram `3 + 2^TYPE_W + 4*r + p` gets the bin of phase gap p, where p=0 is init-issue, p=1 is fwd-init, p=2 is first-fwd and p=3 is done-first.
- R4: An accepted miss with a valid responder `r` whose timestamps are out of order increments incomplete counter `r`. That counter is read at select index `3 + 2^TYPE_W + 4*NRESP + r`. No phase histogram changes.
- R5: A hit, or a miss whose responder code is NRESP or above, changes neither the phase histograms nor any incomplete counter.
- R6: A record with `t_done < t_issue` is discarded and changes no counter.
- R7: Bin width is 2^BIN_SHIFT. The last bin, NBIN-1, also takes every value at or above (NBIN-1)*2^BIN_SHIFT.
- R8: Every counter saturates at all ones and never wraps.
- R9: A high `clr` zeroes all counters at that clock edge. It also discards records presented in that cycle or in the cycle before.
- R10: A record presented before clock edge k shows on `rd_data` after edge k+1. Records on consecutive cycles are all counted.
- R11: `rd_data` combinationally returns the counter chosen by `rd_hist`/`rd_bin`. Incomplete counters ignore `rd_bin`. A histogram index or bin outside the map returns 0.
- R12: After reset every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero all counters, drop in-flight records |
| cmp_valid | input | 1 | Completion record present |
| cmp_hit | input | 1 | 1 = hit, 0 = miss |
| cmp_type | input | TYPE_W | Request type code |
| cmp_resp | input | RESP_W | Responder code, valid below NRESP |
| t_issue | input | TS_W | Issue timestamp |
| t_init | input | TS_W | Initial request timestamp |
| t_fwd | input | TS_W | Forward timestamp |
| t_first | input | TS_W | First response timestamp |
| t_done | input | TS_W | Completion timestamp |
| rd_hist | input | SEL_W | Histogram or incomplete-counter select |
| rd_bin | input | BIN_W | Bin select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
A record presented at a negative edge reaches the first stage at the next rising edge and the counters at the edge after that. It is therefore readable after two rising edges. The bench checks this edge by edge: the selected counter must be unchanged one edge after the record and must have moved one edge later. All other checks wait three idle cycles after the last record before scanning the whole counter map. Scanning only then keeps any in-flight update from being sampled. Clear is probed with records placed one cycle before and in the clearing cycle, and both must be lost.

// File: rtl/lat_phase_prof.sv
module lat_phase_prof #(
  parameter int TS_W      = 16,
  parameter int TYPE_W    = 2,
  parameter int NRESP     = 4,
  parameter int RESP_W    = 3,
  parameter int NBIN      = 10,
  parameter int BIN_SHIFT = 2,
  parameter int CNT_W     = 16,
  localparam int NTYPE    = 1 << TYPE_W,
  localparam int NPH      = 4,
  localparam int H_TYPE   = 3,
  localparam int H_PH     = H_TYPE + NTYPE,
  localparam int NHIST    = H_PH + NPH * NRESP,
  localparam int NSEL     = NHIST + NRESP,
  localparam int SEL_W    = $clog2(NSEL),
  localparam int BIN_W    = $clog2(NBIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmp_valid,
  input  logic              cmp_hit,
  input  logic [TYPE_W-1:0] cmp_type,
  input  logic [RESP_W-1:0] cmp_resp,
  input  logic [TS_W-1:0]   t_issue,
  input  logic [TS_W-1:0]   t_init,
  input  logic [TS_W-1:0]   t_fwd,
  input  logic [TS_W-1:0]   t_first,
  input  logic [TS_W-1:0]   t_done,
  input  logic [SEL_W-1:0]  rd_hist,
  input  logic [BIN_W-1:0]  rd_bin,
  output logic [CNT_W-1:0]  rd_data
);

  function automatic logic [BIN_W-1:0] bin_of(input logic [TS_W-1:0] d);
    logic [TS_W-1:0] q;
    q = d >> BIN_SHIFT;
    return (q > TS_W'(NBIN - 1)) ? BIN_W'(NBIN - 1) : q[BIN_W-1:0];
  endfunction

  wire in_order = (t_issue <= t_init) && (t_init <= t_fwd) &&
                  (t_fwd <= t_first) && (t_first <= t_done);
  wire take     = cmp_valid && (t_done >= t_issue) && !clr;

  logic              s1_v, s1_hit, s1_rok, s1_ord;
  logic [TYPE_W-1:0] s1_type;
  logic [RESP_W-1:0] s1_resp;
  logic [BIN_W-1:0]  s1_bt;
  logic [BIN_W-1:0]  s1_bp [NPH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_hit  <= 1'b0;
      s1_rok  <= 1'b0;
      s1_ord  <= 1'b0;
      s1_type <= '0;
      s1_resp <= '0;
      s1_bt   <= '0;
      for (int p = 0; p < NPH; p++) s1_bp[p] <= '0;
    end else begin
      s1_v    <= take;
      s1_hit  <= cmp_hit;
      s1_rok  <= cmp_resp < RESP_W'(NRESP);
      s1_ord  <= in_order;
      s1_type <= cmp_type;
      s1_resp <= cmp_resp;
      s1_bt   <= bin_of(t_done - t_issue);
      s1_bp[0] <= bin_of(t_init - t_issue);
      s1_bp[1] <= bin_of(t_fwd - t_init);
      s1_bp[2] <= bin_of(t_first - t_fwd);
      s1_bp[3] <= bin_of(t_done - t_first);
    end
  end

  logic [NHIST-1:0] hen;
  logic [BIN_W-1:0] hbin [NHIST];
  logic [NRESP-1:0] ien;

  always_comb begin
    hen = '0;
    ien = '0;
    for (int h = 0; h < NHIST; h++) hbin[h] = s1_bt;
    hen[0] = s1_v;
    hen[1] = s1_v && s1_hit;
    hen[2] = s1_v && !s1_hit;
    for (int t = 0; t < NTYPE; t++)
      hen[H_TYPE + t] = s1_v && (s1_type == TYPE_W'(t));
    for (int r = 0; r < NRESP; r++) begin
      for (int p = 0; p < NPH; p++) begin
        hen[H_PH + r*NPH + p]  = s1_v && !s1_hit && s1_rok &&
                                 (s1_resp == RESP_W'(r)) && s1_ord;
        hbin[H_PH + r*NPH + p] = s1_bp[p];
      end
      ien[r] = s1_v && !s1_hit && s1_rok && (s1_resp == RESP_W'(r)) && !s1_ord;
    end
  end

  logic [CNT_W-1:0] cnt  [NHIST][NBIN];
  logic [CNT_W-1:0] icnt [NRESP];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int h = 0; h < NHIST; h++)
        for (int b = 0; b < NBIN; b++) cnt[h][b] <= '0;
      for (int r = 0; r < NRESP; r++) icnt[r] <= '0;
    end else begin
      for (int h = 0; h < NHIST; h++)
        for (int b = 0; b < NBIN; b++)
          if (hen[h] && hbin[h] == BIN_W'(b) && cnt[h][b] != '1)
            cnt[h][b] <= cnt[h][b] + 1'b1;
      for (int r = 0; r < NRESP; r++)
        if (ien[r] && icnt[r] != '1) icnt[r] <= icnt[r] + 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int h = 0; h < NHIST; h++)
      for (int b = 0; b < NBIN; b++)
        if (rd_hist == SEL_W'(h) && rd_bin == BIN_W'(b)) rd_data = cnt[h][b];
    for (int r = 0; r < NRESP; r++)
      if (rd_hist == SEL_W'(NHIST + r)) rd_data = icnt[r];
  end

  logic [CNT_W+7:0] tot0;
  always_comb begin
    tot0 = '0;
    for (int b = 0; b < NBIN; b++) tot0 = tot0 + (CNT_W+8)'(cnt[0][b]);
  end

  genvar gb, gr;
  generate
    for (gb = 0; gb < NBIN; gb++) begin : g_mono
      assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt[0][gb] >= $past(cnt[0][gb]));
    end
    for (gr = 0; gr < NRESP; gr++) begin : g_inc
      assert_inc_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(s1_v && !s1_hit && s1_rok && s1_resp == RESP_W'(gr)))
        |=> $stable(icnt[gr]));
    end
  endgenerate

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> tot0 == '0);

  assert_one_per_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> tot0 <= $past(tot0) + 1'b1);

  assert_drop_backward_R6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (cmp_valid && t_done < t_issue) |-> ##2 $stable(tot0));

endmodule

// File: tb/lat_phase_prof_tb_top.sv
module lat_phase_prof_tb_top;
  localparam int TS_W = 16, TYPE_W = 2, NRESP = 4, RESP_W = 3;
  localparam int NBIN = 10, BSH = 2, CNT_W = 6;
  localparam int NTYPE = 4, H_PH = 7, NHIST = 23, NSEL = 27, SEL_W = 5, BIN_W = 4;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, clr = 0, cmp_valid = 0, cmp_hit = 0;
  logic [TYPE_W-1:0] cmp_type = 0;
  logic [RESP_W-1:0] cmp_resp = 0;
  logic [TS_W-1:0] t_issue = 0, t_init = 0, t_fwd = 0, t_first = 0, t_done = 0;
  logic [SEL_W-1:0] rd_hist = 0;
  logic [BIN_W-1:0] rd_bin = 0;
  logic [CNT_W-1:0] rd_data;

  int total = 0, bad = 0;
  int mdl [NSEL][NBIN];

  always #4 clk = ~clk;

  lat_phase_prof #(.TS_W(TS_W), .TYPE_W(TYPE_W), .NRESP(NRESP), .RESP_W(RESP_W),
    .NBIN(NBIN), .BIN_SHIFT(BSH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_valid(cmp_valid), .cmp_hit(cmp_hit),
    .cmp_type(cmp_type), .cmp_resp(cmp_resp), .t_issue(t_issue), .t_init(t_init),
    .t_fwd(t_fwd), .t_first(t_first), .t_done(t_done), .rd_hist(rd_hist),
    .rd_bin(rd_bin), .rd_data(rd_data));

  function automatic int bin_of(int d);
    int q = d >> BSH;
    return (q > NBIN - 1) ? NBIN - 1 : q;
  endfunction

  function automatic string req_of(int h);
    if (h == 0 || (h >= 3 && h < H_PH)) return "R1";
    if (h < 3) return "R2";
    if (h < NHIST) return "R3";
    return "R4";
  endfunction

  task automatic bump(int h, int b);
    if (mdl[h][b] < MAXC) mdl[h][b]++;
  endtask

  task automatic model(bit hit, int ty, int rs, int a, int b, int c, int d, int e);
    int bt;
    if (e < a) return;
    bt = bin_of(e - a);
    bump(0, bt);
    bump(hit ? 1 : 2, bt);
    bump(3 + ty, bt);
    if (!hit && rs < NRESP) begin
      if (a <= b && b <= c && c <= d && d <= e) begin
        bump(H_PH + rs*4 + 0, bin_of(b - a));
        bump(H_PH + rs*4 + 1, bin_of(c - b));
        bump(H_PH + rs*4 + 2, bin_of(d - c));
        bump(H_PH + rs*4 + 3, bin_of(e - d));
      end else bump(NHIST + rs, 0);
    end
  endtask

  task automatic send(bit hit, int ty, int rs, int a, int b, int c, int d, int e);
    @(negedge clk);
    cmp_valid = 1; cmp_hit = hit; cmp_type = ty[TYPE_W-1:0]; cmp_resp = rs[RESP_W-1:0];
    t_issue = a[TS_W-1:0]; t_init = b[TS_W-1:0]; t_fwd = c[TS_W-1:0];
    t_first = d[TS_W-1:0]; t_done = e[TS_W-1:0];
    model(hit, ty, rs, a, b, c, d, e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_valid = 0; clr = 0;
    end
  endtask

  task automatic chk(int got, int exp, string rq, string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  task automatic read_at(int h, int b, output int v);
    rd_hist = h[SEL_W-1:0]; rd_bin = b[BIN_W-1:0];
    #1 v = int'(rd_data);
  endtask

  task automatic check_all(string tag);
    int v;
    for (int h = 0; h < NSEL; h++)
      for (int b = 0; b < ((h < NHIST) ? NBIN : 1); b++) begin
        read_at(h, b, v);
        chk(v, mdl[h][b], req_of(h), $sformatf("%s hist %0d bin %0d", tag, h, b));
      end
  endtask

  task automatic zero_model();
    for (int h = 0; h < NSEL; h++)
      for (int b = 0; b < NBIN; b++) mdl[h][b] = 0;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, v0, a, g0, g1, g2, g3, k;
    process::self().srandom(32'd1234);
    zero_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    check_all("reset R12");

    // R10: two-edge latency, lat 5 -> bin 1
    rd_hist = 0; rd_bin = 1;
    #1 v0 = int'(rd_data);
    send(1, 0, 0, 100, 100, 100, 100, 105);
    @(negedge clk); cmp_valid = 0;
    read_at(0, 1, v); chk(v, v0, "R10", "after first edge");
    @(negedge clk);
    read_at(0, 1, v); chk(v, v0 + 1, "R10", "after second edge");
    idle(3);

    // R7 bin edges, R1 type histograms, back-to-back R10
    send(1, 1, 0, 200, 200, 200, 200, 200);
    send(1, 1, 0, 200, 200, 200, 200, 203);
    send(1, 2, 0, 200, 200, 200, 200, 204);
    send(1, 3, 0, 200, 200, 200, 200, 239);
    send(1, 3, 0, 200, 200, 200, 200, 240);
    send(1, 2, 0, 200, 200, 200, 200, 1200);
    idle(3);
    check_all("bins R7");

    // R3 ordered miss with equal stamps; R4 unordered; R5 hit and bad responder
    send(0, 0, 2, 300, 300, 309, 309, 330);
    send(0, 1, 3, 300, 310, 305, 320, 330);
    send(1, 1, 1, 300, 301, 302, 303, 304);
    send(0, 2, 5, 300, 301, 302, 303, 304);
    send(0, 2, 7, 300, 350, 302, 303, 304);
    // R6 backward completion dropped
    send(0, 0, 1, 500, 510, 520, 530, 499);
    idle(3);
    check_all("phases R3");
    read_at(NHIST + 3, 7, v); chk(v, mdl[NHIST + 3][0], "R11", "incomplete any bin");
    read_at(30, 0, v); chk(v, 0, "R11", "select out of map");
    read_at(0, 12, v); chk(v, 0, "R11", "bin out of map");
    read_at(NHIST + 1, 0, v); chk(v, 0, "R6", "backward record no incomplete");

    // R8 saturation of hit bin 0
    for (int i = 0; i < MAXC + 8; i++) send(1, 0, 0, 50, 50, 50, 50, 51);
    idle(3);
    read_at(1, 0, v); chk(v, MAXC, "R8", "hit bin0 saturates");
    check_all("sat R8");

    // R9 clear with records in flight
    send(0, 0, 0, 10, 11, 12, 13, 14);
    @(negedge clk);
    clr = 1; cmp_valid = 1;
    idle(3);
    zero_model();
    check_all("clear R9");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      a = 100 + int'($urandom_range(0, 20000));
      g0 = $urandom_range(0, 12); g1 = $urandom_range(0, 12);
      g2 = $urandom_range(0, 12); g3 = $urandom_range(0, 20);
      k = $urandom_range(0, 9);
      if (k == 0) send($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
                       a, a + g0, a + g0 + g1, a + g0 + g1 + g2, a - 1 - g3);
      else if (k < 3) send(0, $urandom_range(0, 3), $urandom_range(0, 7),
                       a, a + g0 + 3, a + g0, a + g0 + g1, a + g0 + g1 + g2 + g3);
      else send($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
                a, a + g0, a + g0 + g1, a + g0 + g1 + g2, a + g0 + g1 + g2 + g3);
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    check_all("random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule